// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block steps a processor core from normal execution into an interrupt handler. It watches one non-maskable request and eight maskable request lines. All of them are active-high levels. It waits for the core to report that the current instruction has retired. It then saves the processor's state through a stack write port: first the flag word, then the return address, each one 32-bit word below the last. Finally it gives the core three things for one cycle: a flag word with the interrupt-enable bit cleared, the new stack pointer, and the handler vector.

The non-maskable request is taken on its rising level. A line that stays high therefore causes one entry only, until it goes low and rises again. The maskable lines are looked at only while the interrupt-enable bit of the incoming flag word is set. Among them, the lowest-numbered line wins. The non-maskable request outranks every maskable line. The core supplies the current stack pointer, flag word and return address, and takes back the updated values when the done strobe is high.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, `stk_we`, `entry_done`, `flags_load` and `busy` are low until an entry is started.
- R2: An entry starts only on a clock edge where `instr_done` is high and a request is eligible. The first stack write is on the next cycle, and `busy` stays high until the entry completes.
- R3: The first write goes to address `sp_in-4` with the flag word sampled at the start. The next cycle writes the sampled `ret_addr` to `sp_in-8`. No other cycle writes.
- R4: The cycle after the second write, `entry_done`, `flags_load` and `sp_load` are high for exactly one cycle. At that point `sp_out = sp_in-8`, and `flags_out` is the sampled flag word with bit 9 (interrupt enable) cleared.
- R5: Maskable lines are ignored while bit 9 of `flags_in` is 0. No stack write follows.
- R6: When several maskable lines are eligible, the lowest index wins. The vector is 32 plus that index.
- R7: An eligible non-maskable request gives vector 2. It beats any maskable line and is taken even while bit 9 is 0.
- R8: The non-maskable request is captured on its rising level and causes one entry only. While it stays high it causes no further entry, although maskable lines are still served.
- R9: `instr_done` is ignored while an entry is in progress. Requests are sampled only on the edge where the entry starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, active-high level |
| irq_req | input | 8 | Maskable request lines, line 0 highest priority |
| instr_done | input | 1 | Current instruction has retired |
| flags_in | input | 32 | Current flag word, bit 9 is interrupt enable |
| ret_addr | input | 32 | Address to resume at after the handler |
| sp_in | input | 32 | Current stack pointer |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 32 | Stack write address |
| stk_wdata | output | 32 | Stack write data |
| sp_out | output | 32 | Stack pointer after both writes |
| sp_load | output | 1 | Load `sp_out` into the core |
| flags_out | output | 32 | Flag word with interrupt enable cleared |
| flags_load | output | 1 | Load `flags_out` into the core |
| vec_out | output | 8 | Handler vector |
| entry_done | output | 1 | Entry complete, outputs valid |
| busy | output | 1 | Entry in progress |

## Verification
Two things can land on the same clock edge: the non-maskable request rising, and a maskable line with interrupts enabled, both with `instr_done` high. The bench drives them together. It checks that the vector is 2. It then keeps the maskable line and the non-maskable level high and raises `instr_done` again. The second entry must carry the maskable vector, which shows that the held non-maskable level did not fire twice. A second overlap holds `instr_done` and a request high through the write cycles. The bench checks that no second entry starts right after completion.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH_FLAGS,
    ST_PUSH_ADDR,
    ST_FINISH
  } entry_state_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_IRQ:0]   seen;
  logic [NUM_IRQ-1:0] grant;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chain
    assign grant[g]  = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end

  assign any = seen[NUM_IRQ];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic taken,
  output logic eligible
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise     = lvl & ~prev_q;
  assign eligible = pend_q | rise;

  always_comb begin
    prev_d = lvl;
    pend_d = (pend_q | rise) & ~taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import intr_entry_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_IRQ  = 8,
  parameter int VEC_W    = 8,
  parameter int IE_POS   = 9,
  parameter int NMI_VEC  = 2,
  parameter int IRQ_BASE = 32,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int WORD_BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              nmi_elig,
  input  logic              irq_any,
  input  logic [IDX_W-1:0]  irq_idx,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              take_nmi,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [DATA_W-1:0] stk_wdata,
  output logic [ADDR_W-1:0] sp_out,
  output logic              sp_load,
  output logic [DATA_W-1:0] flags_out,
  output logic              flags_load,
  output logic [VEC_W-1:0]  vec_out,
  output logic              entry_done,
  output logic              busy
);
  entry_state_t      state_q, state_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [DATA_W-1:0] flags_q;
  logic [ADDR_W-1:0] addr_q, sp_q;
  logic              irq_ok, start;

  assign irq_ok   = irq_any & flags_in[IE_POS];
  assign start    = (state_q == ST_IDLE) & instr_done & (nmi_elig | irq_ok);
  assign take_nmi = start & nmi_elig;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (start) state_d = ST_PUSH_FLAGS;
      ST_PUSH_FLAGS: state_d = ST_PUSH_ADDR;
      ST_PUSH_ADDR:  state_d = ST_FINISH;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (nmi_elig) vec_d = VEC_W'(NMI_VEC);
    else          vec_d = VEC_W'(IRQ_BASE) + VEC_W'(irq_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      flags_q <= '0;
      addr_q  <= '0;
      sp_q    <= '0;
    end else if (start) begin
      vec_q   <= vec_d;
      flags_q <= flags_in;
      addr_q  <= ret_addr;
      sp_q    <= sp_in;
    end
  end

  always_comb begin
    stk_we    = 1'b0;
    stk_addr  = '0;
    stk_wdata = '0;
    case (state_q)
      ST_PUSH_FLAGS: begin
        stk_we    = 1'b1;
        stk_addr  = sp_q - ADDR_W'(WORD_BYTES);
        stk_wdata = flags_q;
      end
      ST_PUSH_ADDR: begin
        stk_we    = 1'b1;
        stk_addr  = sp_q - ADDR_W'(2 * WORD_BYTES);
        stk_wdata = DATA_W'(addr_q);
      end
      default: ;
    endcase
  end

  assign entry_done = (state_q == ST_FINISH);
  assign sp_load    = entry_done;
  assign flags_load = entry_done;
  assign vec_out    = vec_q;
  assign sp_out     = sp_q - ADDR_W'(2 * WORD_BYTES);
  assign flags_out  = flags_q & ~(DATA_W'(1) << IE_POS);
  assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_IRQ  = 8,
  parameter int VEC_W    = 8,
  parameter int IE_POS   = 9,
  parameter int NMI_VEC  = 2,
  parameter int IRQ_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               instr_done,
  input  logic [DATA_W-1:0]  flags_in,
  input  logic [ADDR_W-1:0]  ret_addr,
  input  logic [ADDR_W-1:0]  sp_in,
  output logic               stk_we,
  output logic [ADDR_W-1:0]  stk_addr,
  output logic [DATA_W-1:0]  stk_wdata,
  output logic [ADDR_W-1:0]  sp_out,
  output logic               sp_load,
  output logic [DATA_W-1:0]  flags_out,
  output logic               flags_load,
  output logic [VEC_W-1:0]   vec_out,
  output logic               entry_done,
  output logic               busy
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic             nmi_elig, take_nmi, irq_any;
  logic [IDX_W-1:0] irq_idx;

  nmi_edge_latch i_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (nmi_req),
    .taken    (take_nmi),
    .eligible (nmi_elig)
  );

  irq_prio_pick #(.NUM_IRQ(NUM_IRQ)) i_pick (
    .req (irq_req),
    .any (irq_any),
    .idx (irq_idx)
  );

  entry_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W),
    .IE_POS(IE_POS), .NMI_VEC(NMI_VEC), .IRQ_BASE(IRQ_BASE)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .nmi_elig   (nmi_elig),
    .irq_any    (irq_any),
    .irq_idx    (irq_idx),
    .flags_in   (flags_in),
    .ret_addr   (ret_addr),
    .sp_in      (sp_in),
    .take_nmi   (take_nmi),
    .stk_we     (stk_we),
    .stk_addr   (stk_addr),
    .stk_wdata  (stk_wdata),
    .sp_out     (sp_out),
    .sp_load    (sp_load),
    .flags_out  (flags_out),
    .flags_load (flags_load),
    .vec_out    (vec_out),
    .entry_done (entry_done),
    .busy       (busy)
  );
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int NUM_IRQ  = 8,
  parameter int IE_POS   = 9,
  parameter int NMI_VEC  = 2,
  parameter int IRQ_BASE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stk_we,
  input logic [ADDR_W-1:0] stk_addr,
  input logic              entry_done,
  input logic              flags_load,
  input logic [DATA_W-1:0] flags_out,
  input logic [VEC_W-1:0]  vec_out,
  input logic              busy
);
  // R3: the second write follows the first, one word lower
  a_r3_second_push: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && !$past(stk_we)) |=> (stk_we && stk_addr == $past(stk_addr) - ADDR_W'(4)));

  // R3: at most two consecutive writes
  a_r3_two_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && $past(stk_we)) |=> !stk_we);

  // R4: completion directly follows a write and lasts one cycle
  a_r4_done_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> ($past(stk_we) && !stk_we));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done);

  // R4: interrupt enable is cleared in the flag word handed back
  a_r4_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    flags_load |-> !flags_out[IE_POS]);

  // R2: writes happen only while busy
  a_r2_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we || entry_done) |-> busy);

  // R6 / R7: vector is in the legal set
  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> (vec_out == VEC_W'(NMI_VEC) ||
                    (vec_out >= VEC_W'(IRQ_BASE) && vec_out < VEC_W'(IRQ_BASE + NUM_IRQ))));
endmodule

bind intr_entry_seq intr_entry_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .NUM_IRQ(NUM_IRQ),
  .IE_POS(IE_POS), .NMI_VEC(NMI_VEC), .IRQ_BASE(IRQ_BASE)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stk_we     (stk_we),
  .stk_addr   (stk_addr),
  .entry_done (entry_done),
  .flags_load (flags_load),
  .flags_out  (flags_out),
  .vec_out    (vec_out),
  .busy       (busy)
);

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_req;
  logic [7:0]  irq_req;
  logic        instr_done;
  logic [31:0] flags_in, ret_addr, sp_in;
  logic        stk_we, sp_load, flags_load, entry_done, busy;
  logic [31:0] stk_addr, stk_wdata, sp_out, flags_out;
  logic [7:0]  vec_out;

  int n_run  = 0;
  int n_fail = 0;

  localparam logic [31:0] FLAG_BASE = 32'hC0DE_0051; // bit 9 clear

  // {nmi[18], irq[17:10], ie[9], take[8], vec[7:0]}
  localparam int NROW = 7;
  localparam logic [18:0] TBL [NROW] = '{
    {1'b0, 8'b0000_0001, 1'b1, 1'b1, 8'd32},  // R6 single line 0
    {1'b0, 8'b1010_0000, 1'b1, 1'b1, 8'd37},  // R6 lowest index wins
    {1'b0, 8'b1000_0000, 1'b1, 1'b1, 8'd39},  // R6 top line
    {1'b0, 8'b0001_0100, 1'b0, 1'b0, 8'd0},   // R5 masked
    {1'b1, 8'b0000_0000, 1'b0, 1'b1, 8'd2},   // R7 nmi while masked
    {1'b1, 8'b0000_0010, 1'b1, 1'b1, 8'd2},   // R7 nmi beats irq
    {1'b0, 8'b0110_0000, 1'b1, 1'b1, 8'd37}   // R6
  };

  intr_entry_seq i_intr_entry_seq (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
    .instr_done(instr_done), .flags_in(flags_in), .ret_addr(ret_addr),
    .sp_in(sp_in), .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .sp_out(sp_out), .sp_load(sp_load), .flags_out(flags_out),
    .flags_load(flags_load), .vec_out(vec_out), .entry_done(entry_done), .busy(busy)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one instr_done cycle and check the whole entry (or its absence).
  task automatic run_entry(input logic nmi, input logic [7:0] irq, input logic ie,
                           input logic take, input logic [7:0] vec,
                           input logic [31:0] sp, input logic [31:0] ra, input string req);
    logic [31:0] fl;
    fl = FLAG_BASE | (32'(ie) << 9);
    @(negedge clk);
    nmi_req = nmi; irq_req = irq; flags_in = fl; ret_addr = ra; sp_in = sp;
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    if (!take) begin
      chk({req, " no write"}, 32'(stk_we), 32'd0);
      chk({req, " not busy"}, 32'(busy), 32'd0);
    end else begin
      chk("R2 first write", 32'(stk_we), 32'd1);
      chk("R3 flags addr", stk_addr, sp - 32'd4);
      chk("R3 flags data", stk_wdata, fl);
      @(negedge clk);
      chk("R3 addr write", 32'(stk_we), 32'd1);
      chk("R3 ret addr", stk_addr, sp - 32'd8);
      chk("R3 ret data", stk_wdata, ra);
      @(negedge clk);
      chk("R4 done", 32'({entry_done, sp_load, flags_load, stk_we}), 32'b1110);
      chk({req, " vector"}, 32'(vec_out), 32'(vec));
      chk("R4 sp_out", sp_out, sp - 32'd8);
      chk("R4 flags_out", flags_out, FLAG_BASE);
      @(negedge clk);
      chk("R4 done one cycle", 32'(entry_done), 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nmi_req = 1'b0; irq_req = '0; instr_done = 1'b0;
    flags_in = '0; ret_addr = '0; sp_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset we", 32'(stk_we), 32'd0);
    chk("R1 reset done", 32'({entry_done, flags_load, busy}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    irq_req = 8'hFF; flags_in = FLAG_BASE | 32'h200;
    @(negedge clk);
    chk("R2 no start without instr_done", 32'(busy), 32'd0);
    irq_req = '0;

    for (int r = 0; r < NROW; r++) begin
      run_entry(TBL[r][18], TBL[r][17:10], TBL[r][9], TBL[r][8], TBL[r][7:0],
                32'h0000_8000 + 32'(r * 64), 32'h1000_0000 + 32'(r), "R6/R7 table");
      @(negedge clk);
      nmi_req = 1'b0; irq_req = '0;
      @(negedge clk);
    end

    // R8: same-cycle nmi rise and irq; nmi held high, irq then served
    run_entry(1'b1, 8'b0000_1000, 1'b1, 1'b1, 8'd2, 32'h0000_4000, 32'hAAAA_0000, "R7 overlap");
    run_entry(1'b1, 8'b0000_1000, 1'b1, 1'b1, 8'd35, 32'h0000_4000, 32'hAAAA_0004, "R8 held nmi");
    run_entry(1'b1, 8'b0000_0000, 1'b0, 1'b0, 8'd0, 32'h0000_4000, 32'hAAAA_0008, "R8 held nmi");
    @(negedge clk);
    nmi_req = 1'b0; irq_req = '0;
    @(negedge clk);
    run_entry(1'b1, 8'b0000_0000, 1'b0, 1'b1, 8'd2, 32'h0000_3000, 32'hBBBB_0000, "R8 re-armed");
    @(negedge clk);
    nmi_req = 1'b0;

    // R9: instr_done held through the writes is ignored
    @(negedge clk);
    irq_req = 8'b0000_0100; flags_in = FLAG_BASE | 32'h200; sp_in = 32'h2000;
    ret_addr = 32'hCCCC_0000; instr_done = 1'b1;
    @(negedge clk);
    chk("R9 first write", stk_addr, 32'h1FFC);
    sp_in = 32'h9000; ret_addr = 32'h1234_5678;
    @(negedge clk);
    chk("R9 sampled ret", stk_wdata, 32'hCCCC_0000);
    instr_done = 1'b0;
    @(negedge clk);
    chk("R9 done", 32'(entry_done), 32'd1);
    chk("R9 sampled sp", sp_out, 32'h1FF8);
    @(negedge clk);
    chk("R9 no restart", 32'({stk_we, busy}), 32'd0);
    irq_req = '0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule